// File: doc/BRIEF.md
# Request Pacing Timer

This block produces the request strobes that pace a pattern-generation engine, whether the engine is capturing data or producing a waveform. It runs in one of two modes. In the internal mode it counts clock cycles and issues one request pulse per programmable interval. Each pulse is asserted for exactly one cycle. In the external mode it watches an incoming request line. The line passes through a synchronizer, and the block measures how long each pulse stays asserted, how long the line stayed idle before it, and the sum of the two. A pulse that meets all three minimums becomes a one-cycle strobe. A pulse that misses any of them raises a sticky error and produces no strobe.

A start input begins pacing and a stop input halts it. The clock is the pacing timebase, so all widths and intervals are counted in its cycles. One polarity input sets the active level of both the generated request output and the incoming request line. The block carries no data, so it has no valid/ready stream. Every pin is a plain control or status signal. The single-cycle strobe `stb_o` drives the data latch downstream, and that latch cannot apply back-pressure.

Top module: `reqt_pacer`

## Requirements
- R1: While reset is held, `running_o`, `stb_o` and `err_o` are 0 and `req_o` sits at its inactive level, which is equal to `req_pol_i`.
- R2: In internal mode (`ext_mode_i`=0), a start accepted at a clock edge makes `stb_o` and the request active in the cycle after that edge, and again every P cycles after it. P is the value of `interval_i` captured at the start, and later changes to `interval_i` are ignored until the next start.
- R3: Each internal request is active for exactly one cycle, and an `interval_i` of 0 or 1 is treated as 2.
- R4: With `req_pol_i`=0 the request output and `ext_req_i` are active high. With `req_pol_i`=1 both are active low.
- R5: In external mode (`ext_mode_i`=1), `ext_req_i` passes through SYNC_STAGES (default 2) flops. A qualifying pulse gives one `stb_o` cycle that starts two clock edges after the first edge that samples the line back at its idle level.
- R6: A pulse qualifies when all three of these hold: it stays asserted for at least MIN_ASSERT sampled cycles (default 2), the idle run before it lasts at least MIN_IDLE cycles (default 2), and the two runs together last at least MIN_PERIOD cycles (default 5). For the first pulse after a start, the idle run counts as unlimited.
- R7: A pulse that fails R6 gives no strobe and sets `err_o` one cycle after the strobe would have appeared. `err_o` stays set until the next accepted start.
- R8: A start is accepted when `start_i`=1 and `stop_i`=0. A start restarts the interval count even while pacing is running. When `stop_i`=1, `running_o` falls at that edge and no further request or strobe follows.
- R9: External pulses have no effect when pacing is stopped. A pulse that is already asserted when a start is accepted is also ignored. In external mode `req_o` stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| ext_mode_i | input | 1 | 0 = internal interval pacing, 1 = qualify external requests |
| req_pol_i | input | 1 | 1 = request output and request input are active low |
| interval_i | input | INT_W | Internal request period in cycles, captured at start |
| start_i | input | 1 | Begin or restart pacing |
| stop_i | input | 1 | Halt pacing, has priority over start |
| ext_req_i | input | 1 | Asynchronous external request line |
| req_o | output | 1 | Generated request pulse at the selected polarity |
| stb_o | output | 1 | One-cycle sample/update strobe to the data latch |
| running_o | output | 1 | Pacing is enabled |
| err_o | output | 1 | Sticky flag: an external pulse broke a width rule |

## Verification
The bench targets the clamp of the interval at 0 and 1. A design that skips the clamp would hold the request active permanently or wrap its counter. It also targets an `interval_i` that changes in the middle of a run, which an uncaptured design would follow at once. On the external side it drives pulses that sit exactly on each minimum and one cycle below each minimum, in turn. An off-by-one in any width comparison therefore shows up as a strobe where an error is expected, or the reverse. It also drives a line that is already asserted at start and pulses sent while stopped, which catch a design that arms too early or keeps counting while halted.

// File: rtl/reqt_pkg.sv
package reqt_pkg;
  typedef enum logic {PACE_INT = 1'b0, PACE_EXT = 1'b1} pace_mode_e;
  localparam int unsigned MIN_INTERVAL = 2;
endpackage

// File: rtl/reqt_sync.sv
module reqt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sh[i] <= 1'b0;
        else        sh[i] <= sh[i-1];
      end
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/reqt_int_gen.sv
module reqt_int_gen
  import reqt_pkg::*;
#(
  parameter int unsigned INT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             en,
  input  logic [INT_W-1:0] interval,
  output logic             act
);
  localparam logic [INT_W-1:0] IVAL_MIN = INT_W'(MIN_INTERVAL);

  logic [INT_W-1:0] ival_q;
  logic [INT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ival_q <= IVAL_MIN;
      cnt_q  <= '0;
    end else if (load) begin
      ival_q <= (interval < IVAL_MIN) ? IVAL_MIN : interval;
      cnt_q  <= '0;
    end else if (en) begin
      cnt_q <= (cnt_q == ival_q - INT_W'(1)) ? '0 : cnt_q + INT_W'(1);
    end
  end

  assign act = en && (cnt_q == '0);

  // one active cycle per request unless restarted
  assert_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act && !load |=> !act);

  // captured interval does not follow the input mid-run
  assert_ival_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ival_q));
endmodule

// File: rtl/reqt_ext_qual.sv
module reqt_ext_qual #(
  parameter int unsigned MIN_ASSERT = 2,
  parameter int unsigned MIN_IDLE   = 2,
  parameter int unsigned MIN_PERIOD = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic line,
  output logic ok,
  output logic bad
);
  localparam int unsigned CW = $clog2(MIN_PERIOD + 1);
  localparam logic [CW-1:0] CAP = CW'(MIN_PERIOD);

  logic          a_d, armed;
  logic [CW-1:0] alen_q, ilen_q;
  logic          fall, pass, end_ev;
  logic [CW:0]   sum;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == CAP) ? v : v + CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_d    <= 1'b0;
      armed  <= 1'b0;
      alen_q <= '0;
      ilen_q <= CAP;
    end else begin
      a_d <= line;
      if (clr) begin
        armed  <= 1'b0;
        alen_q <= '0;
        ilen_q <= CAP;
      end else if (line) begin
        alen_q <= a_d ? sat_inc(alen_q) : CW'(1);
        if (en && !a_d) armed <= 1'b1;
      end else begin
        ilen_q <= a_d ? CW'(1) : sat_inc(ilen_q);
        if (a_d) armed <= 1'b0;
      end
    end
  end

  assign fall   = a_d && !line;
  assign sum    = {1'b0, alen_q} + {1'b0, ilen_q};
  assign pass   = (alen_q >= CW'(MIN_ASSERT)) && (ilen_q >= CW'(MIN_IDLE)) &&
                  (sum >= (CW+1)'(MIN_PERIOD));
  assign end_ev = en && armed && fall;
  assign ok     = end_ev && pass;
  assign bad    = end_ev && !pass;

  assert_ok_bad_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok, bad}));

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ok |=> !ok);
endmodule

// File: rtl/reqt_pacer.sv
module reqt_pacer
  import reqt_pkg::*;
#(
  parameter int unsigned INT_W       = 16,
  parameter int unsigned MIN_ASSERT  = 2,
  parameter int unsigned MIN_IDLE    = 2,
  parameter int unsigned MIN_PERIOD  = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode_i,
  input  logic             req_pol_i,
  input  logic [INT_W-1:0] interval_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             ext_req_i,
  output logic             req_o,
  output logic             stb_o,
  output logic             running_o,
  output logic             err_o
);
  pace_mode_e mode;
  logic running_q, err_q, start_eff;
  logic ext_s, line_act, int_act, ext_ok, ext_bad;

  assign mode      = pace_mode_e'(ext_mode_i);
  assign start_eff = start_i && !stop_i;

  always_ff @(posedge clk) begin
    if (!rst_n)        running_q <= 1'b0;
    else if (stop_i)   running_q <= 1'b0;
    else if (start_i)  running_q <= 1'b1;
  end

  reqt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_req_i), .q(ext_s)
  );

  assign line_act = ext_s ^ req_pol_i;

  reqt_int_gen #(.INT_W(INT_W)) u_int (
    .clk(clk), .rst_n(rst_n), .load(start_eff),
    .en(running_q && (mode == PACE_INT)),
    .interval(interval_i), .act(int_act)
  );

  reqt_ext_qual #(
    .MIN_ASSERT(MIN_ASSERT), .MIN_IDLE(MIN_IDLE), .MIN_PERIOD(MIN_PERIOD)
  ) u_ext (
    .clk(clk), .rst_n(rst_n), .clr(start_eff),
    .en(running_q && (mode == PACE_EXT)),
    .line(line_act), .ok(ext_ok), .bad(ext_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (start_eff) err_q <= 1'b0;
    else if (ext_bad)   err_q <= 1'b1;
  end

  assign stb_o     = int_act || ext_ok;
  assign req_o     = int_act ^ req_pol_i;
  assign running_o = running_q;
  assign err_o     = err_q;

  assert_stop_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !running_q);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !start_eff |=> err_q);

  assert_stb_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> running_q);
endmodule

// File: tb/sim_reqt_pacer.sv
module sim_reqt_pacer;
  localparam int IW = 16, MA = 2, MI = 2, MP = 5, BIG = 100000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ext_mode, pol, start, stop, ext;
  logic [IW-1:0] ival;
  logic req_o, stb_o, running_o, err_o;

  reqt_pacer u0 (
    .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode), .req_pol_i(pol),
    .interval_i(ival), .start_i(start), .stop_i(stop), .ext_req_i(ext),
    .req_o(req_o), .stb_o(stb_o), .running_o(running_o), .err_o(err_o)
  );

  int n_tests = 0, n_fail = 0, stb_cnt = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: integer run lengths, modulo position
  int m_run, m_pos, m_ival, m_err, m_armed, m_alen, m_ilen, m_ad, m_p1, m_p2;
  always @(posedge clk) begin
    int c_rst, c_mode, c_pol, c_start, c_stop, c_ext, c_int;
    int a_now, en, fall, pass, bad_ev, act, e_stb;
    c_rst = rst_n; c_mode = ext_mode; c_pol = pol; c_start = start;
    c_stop = stop; c_ext = ext; c_int = ival;
    #2;
    a_now = m_p2 ^ c_pol;
    en = m_run && c_mode;
    fall = m_ad && !a_now;
    pass = (m_alen >= MA) && (m_ilen >= MI) && (m_alen + m_ilen >= MP);
    bad_ev = en && m_armed && fall && !pass;
    if (!c_rst) begin
      m_run = 0; m_pos = 0; m_ival = 2; m_err = 0; m_armed = 0;
      m_alen = 0; m_ilen = BIG; m_ad = 0; m_p1 = 0; m_p2 = 0;
    end else begin
      if (c_start && !c_stop) m_err = 0;
      else if (bad_ev) m_err = 1;
      if (c_start && !c_stop) begin
        m_pos = 0; m_ival = (c_int < 2) ? 2 : c_int;
        m_armed = 0; m_ilen = BIG; m_alen = 0;
      end else begin
        if (m_run && !c_mode) m_pos++;
        if (a_now) begin
          m_alen = m_ad ? m_alen + 1 : 1;
          if (en && !m_ad) m_armed = 1;
        end else begin
          m_ilen = m_ad ? 1 : m_ilen + 1;
          if (m_ad) m_armed = 0;
        end
      end
      m_run = c_stop ? 0 : (c_start ? 1 : m_run);
      m_ad = a_now; m_p2 = m_p1; m_p1 = c_ext;
    end
    act = m_run && !c_mode && (m_pos % m_ival == 0);
    pass = (m_alen >= MA) && (m_ilen >= MI) && (m_alen + m_ilen >= MP);
    e_stb = act || (m_run && c_mode && m_armed && m_ad && !(m_p2 ^ c_pol) && pass);
    if (c_rst) begin
      chk("R2/R4 req_o", req_o, act ^ c_pol);
      chk("R5/R6 stb_o", stb_o, e_stb);
      chk("R7 err_o", err_o, m_err);
      chk("R8 running_o", running_o, m_run);
    end
    if (stb_o) stb_cnt++;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    start = 1; cyc(1); start = 0;
  endtask

  task automatic do_stop();
    stop = 1; cyc(1); stop = 0;
  endtask

  task automatic ext_pulse(int a, int i);
    ext = ~pol; cyc(a);
    ext = pol;  cyc(i);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int s;
    rst_n = 0; ext_mode = 0; pol = 0; start = 0; stop = 0; ext = 0; ival = 4;
    cyc(3);
    chk("R1 running", running_o, 0);
    chk("R1 stb", stb_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 req idle", req_o, 0);
    rst_n = 1; cyc(2);

    // R2: interval 4, offsets 0..19 give 5 strobes
    s = stb_cnt; do_start(); cyc(19);
    chk("R2 strobe count interval 4", stb_cnt - s, 5);
    do_stop();
    chk("R8 stopped", running_o, 0);
    s = stb_cnt; cyc(10);
    chk("R8 no strobe after stop", stb_cnt - s, 0);

    // R3 clamp
    ival = 0; s = stb_cnt; do_start(); cyc(9);
    chk("R3 interval 0 clamped", stb_cnt - s, 5);
    do_stop();
    ival = 1; s = stb_cnt; do_start(); cyc(9);
    chk("R3 interval 1 clamped", stb_cnt - s, 5);
    do_stop();

    // R4 active-low request
    pol = 1; cyc(1);
    chk("R4 idle high", req_o, 1);
    ival = 3; s = stb_cnt; do_start(); cyc(8);
    chk("R4 strobe count active low", stb_cnt - s, 3);
    do_stop(); pol = 0; cyc(1);

    // R2 interval captured at start
    ival = 5; s = stb_cnt; start = 1; cyc(1); start = 0; ival = 2; cyc(14);
    chk("R2 interval held", stb_cnt - s, 3);
    do_stop();

    // R8 start with stop
    start = 1; stop = 1; cyc(1); start = 0; stop = 0;
    chk("R8 stop wins", running_o, 0);

    // R5 external good pulses
    ext_mode = 1; ext = 0; cyc(3);
    s = stb_cnt; do_start();
    ext_pulse(3, 3); ext_pulse(3, 3); ext_pulse(3, 3); cyc(2);
    chk("R5 three good pulses", stb_cnt - s, 3);
    chk("R6 no error", err_o, 0);
    chk("R9 req idle in ext mode", req_o, 0);

    // R7 short assertion
    s = stb_cnt; ext_pulse(1, 4);
    chk("R7 short pulse no strobe", stb_cnt - s, 0);
    chk("R7 error set", err_o, 1);
    cyc(5);
    chk("R7 error sticky", err_o, 1);
    do_start(); cyc(1);
    chk("R7 start clears", err_o, 0);

    // R6 short idle before second pulse
    cyc(2); s = stb_cnt; do_start();
    ext_pulse(2, 1); ext_pulse(3, 4);
    chk("R6 idle rule strobes", stb_cnt - s, 1);
    chk("R6 idle rule error", err_o, 1);

    // R6 period rule: 2+2 < 5
    s = stb_cnt; do_start();
    ext_pulse(2, 2); ext_pulse(2, 4);
    chk("R6 period rule strobes", stb_cnt - s, 1);
    chk("R6 period rule error", err_o, 1);

    // R6 exact boundary 2+3 = 5 passes
    s = stb_cnt; do_start();
    ext_pulse(2, 3); ext_pulse(2, 4);
    chk("R6 boundary strobes", stb_cnt - s, 2);
    chk("R6 boundary no error", err_o, 0);

    // R9 ignored while stopped
    do_stop(); s = stb_cnt;
    ext_pulse(1, 3); ext_pulse(3, 3);
    chk("R9 stopped no strobe", stb_cnt - s, 0);
    chk("R9 stopped no error", err_o, 0);

    // R9 pulse in progress at start
    ext = 1; cyc(4); s = stb_cnt; do_start(); cyc(2); ext = 0; cyc(5);
    chk("R9 pre-start pulse ignored", stb_cnt - s, 0);
    chk("R9 pre-start pulse no error", err_o, 0);

    // R4 active-low external line
    do_stop(); pol = 1; ext = 1; cyc(4);
    s = stb_cnt; do_start();
    ext_pulse(3, 3); ext_pulse(3, 3); cyc(2);
    chk("R4 active-low ext strobes", stb_cnt - s, 2);
    chk("R4 active-low ext no error", err_o, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule